// File: doc/BRIEF.md
# Dual-Port Half-Word Mailbox Store

This block is a small shared message store of 24 entries, each 32 bits wide, that two agents reach through 16-bit ports. One agent is a serial protocol engine, called the controller here. The other is a host CPU. Each address carries the entry number in its upper five bits and the half of that entry in its lowest bit. The controller reads or writes one half-word per clock.

A CPU read also finishes in one clock. A CPU write cannot change 16 bits of the 32-bit entry on its own. The block therefore spends two clocks on it: it reads the whole entry and latches it, then writes back the entry with the new half-word merged in. During the first of those clocks it holds the CPU off with a stall output.

The controller always has priority. A CPU request that meets a controller access waits, with stall high, for the next free cycle. If the controller steps in during the write-back cycle of a CPU write, that write starts over from its read, so the merge never uses stale data. Entry numbers past the last entry store nothing, read back as zero and raise a one-cycle flag.

Top module: `mbox_ram_arb`

## Requirements
- R1: After synchronous reset, every entry reads 0. Both read-data outputs, `illegal_addr` and `cpu_stall` (with no CPU request pending) are 0.
- R2: Address bits [5:1] select the entry. Bit 0 selects the half: 0 is bits 15:0 and 1 is bits 31:16.
- R3: A controller access sampled with `ctl_en_n` low completes at that clock edge. Read data is valid from the following cycle. A written half-word is visible to a read issued in the next cycle.
- R4: A CPU read with no controller access in the same cycle sees `cpu_stall` low and completes at that edge. `cpu_rdata` is valid in the following cycle.
- R5: A CPU write with no controller access takes two cycles. `cpu_stall` is high in the first cycle and low in the second, and the write completes at the end of the second.
- R6: A CPU write changes only the addressed half-word. The other half of the entry keeps the value it had.
- R7: A controller access has priority. When both ports are enabled, `cpu_stall` is high and the CPU access has no effect in that cycle. A controller access during the write-back cycle of a CPU write restarts that write from its read phase, and the controller's data is kept.
- R8: An entry number of 24 to 31 writes nothing and reads 0. `illegal_addr` is high for one cycle, in the cycle after each such access completes.
- R9: With both enables high, no entry changes, both read-data outputs hold their values and `illegal_addr` stays low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_en_n | input | 1 | Controller access enable, active low |
| ctl_we | input | 1 | Controller direction, 1 = write |
| ctl_addr | input | 6 | Controller half-word address |
| ctl_wdata | input | 16 | Controller write data |
| ctl_rdata | output | 16 | Controller read data |
| cpu_en_n | input | 1 | CPU access enable, active low; held until stall is low |
| cpu_we | input | 1 | CPU direction, 1 = write |
| cpu_addr | input | 6 | CPU half-word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data |
| cpu_stall | output | 1 | CPU wait request |
| illegal_addr | output | 1 | One-cycle flag for an out-of-range entry |

## Verification
Suppose the write-back latch held a stale or wrong entry. That error would show at the ports on the next read of the partner half-word, one access after the CPU write. Suppose the sequencer stayed in the wrong phase. `cpu_stall` would then be wrong in the very cycle it is sampled. A missed restart after controller interference would surface as a lost controller half-word on the read-back two cycles later. The sweeps write and read every address from both ports, so a wrong decode of any entry or any half shows up on a data check.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int MBX_ENTRIES = 24;
    localparam int MBX_HALF_W  = 16;
    localparam int MBX_ADDR_W  = 6;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_MERGE = 1'b1
    } cpu_phase_e;

    typedef struct packed {
        logic stall;
        logic done;
        logic capture;
        logic commit;
    } seq_ctl_t;
endpackage

// File: rtl/mbox_cpu_seq.sv
module mbox_cpu_seq
    import mbox_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  logic     we,
    input  logic     ctl_busy,
    output seq_ctl_t ctl
);
    cpu_phase_e phase_q, phase_d;

    always_comb begin
        ctl     = '0;
        phase_d = PH_IDLE;
        if (req) begin
            if (phase_q == PH_MERGE) begin
                if (ctl_busy) begin
                    ctl.stall = 1'b1;          // restart from the read phase
                end else begin
                    ctl.done   = 1'b1;
                    ctl.commit = 1'b1;
                end
            end else if (ctl_busy) begin
                ctl.stall = 1'b1;
            end else if (we) begin
                ctl.stall   = 1'b1;
                ctl.capture = 1'b1;
                phase_d     = PH_MERGE;
            end else begin
                ctl.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assert_ctl_priority_R7: assert property (@(posedge clk) disable iff (rst)
        (req && ctl_busy) |-> (ctl.stall && !ctl.done));

    assert_one_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (req && we && ctl.done) |-> $past(ctl.stall));

    assert_read_no_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (req && !we && !ctl_busy) |-> !ctl.stall);
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
    parameter int ENTRIES = 24,
    parameter int HALF_W  = 16,
    parameter int IDX_W   = 5,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [IDX_W-1:0]  ctl_idx,
    input  logic              ctl_hi,
    input  logic [HALF_W-1:0] ctl_half,
    input  logic              m_wr,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [WORD_W-1:0] m_word,
    output logic [WORD_W-1:0] ctl_word,
    output logic [WORD_W-1:0] cpu_word
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [WORD_W-1:0] words [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (m_wr && cpu_idx == IDX_W'(e)) begin
                word_q <= m_word;
            end else if (ctl_wr && ctl_idx == IDX_W'(e)) begin
                if (ctl_hi) word_q[WORD_W-1:HALF_W] <= ctl_half;
                else        word_q[HALF_W-1:0]      <= ctl_half;
            end
        end
        assign words[e] = word_q;
    end

    assign ctl_word = (ctl_idx <= LAST_IDX) ? words[ctl_idx] : '0;
    assign cpu_word = (cpu_idx <= LAST_IDX) ? words[cpu_idx] : '0;

    assert_single_writer_R7: assert property (@(posedge clk) disable iff (rst)
        !(m_wr && ctl_wr));

    assert_legal_write_R8: assert property (@(posedge clk) disable iff (rst)
        (m_wr |-> cpu_idx <= LAST_IDX) and (ctl_wr |-> ctl_idx <= LAST_IDX));
endmodule

// File: rtl/mbox_ram_arb.sv
module mbox_ram_arb
    import mbox_pkg::*;
#(
    parameter int ENTRIES = MBX_ENTRIES,
    parameter int HALF_W  = MBX_HALF_W,
    parameter int ADDR_W  = MBX_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_en_n,
    input  logic              ctl_we,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic [HALF_W-1:0] ctl_wdata,
    output logic [HALF_W-1:0] ctl_rdata,
    input  logic              cpu_en_n,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [HALF_W-1:0] cpu_wdata,
    output logic [HALF_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              illegal_addr
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int IDX_W  = ADDR_W - 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic              ctl_act, cpu_act, ctl_hi, cpu_hi, ctl_ok, cpu_ok;
    logic [IDX_W-1:0]  ctl_idx, cpu_idx;
    logic [WORD_W-1:0] ctl_word, cpu_word, hold_q, merged;
    seq_ctl_t          seq;

    assign ctl_act = !ctl_en_n;
    assign cpu_act = !cpu_en_n;
    assign ctl_idx = ctl_addr[ADDR_W-1:1];
    assign cpu_idx = cpu_addr[ADDR_W-1:1];
    assign ctl_hi  = ctl_addr[0];
    assign cpu_hi  = cpu_addr[0];
    assign ctl_ok  = ctl_idx <= LAST_IDX;
    assign cpu_ok  = cpu_idx <= LAST_IDX;

    mbox_cpu_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (cpu_act),
        .we       (cpu_we),
        .ctl_busy (ctl_act),
        .ctl      (seq)
    );

    mbox_store #(.ENTRIES(ENTRIES), .HALF_W(HALF_W), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_act && ctl_we && ctl_ok),
        .ctl_idx  (ctl_idx),
        .ctl_hi   (ctl_hi),
        .ctl_half (ctl_wdata),
        .m_wr     (seq.commit && cpu_ok),
        .cpu_idx  (cpu_idx),
        .m_word   (merged),
        .ctl_word (ctl_word),
        .cpu_word (cpu_word)
    );

    // read phase of a CPU write: latch the whole entry
    always_ff @(posedge clk) begin
        if (rst)              hold_q <= '0;
        else if (seq.capture) hold_q <= cpu_word;
    end

    always_comb begin
        merged = hold_q;
        if (cpu_hi) merged[WORD_W-1:HALF_W] = cpu_wdata;
        else        merged[HALF_W-1:0]      = cpu_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_rdata    <= '0;
            cpu_rdata    <= '0;
            illegal_addr <= 1'b0;
        end else begin
            if (ctl_act && !ctl_we)
                ctl_rdata <= ctl_hi ? ctl_word[WORD_W-1:HALF_W] : ctl_word[HALF_W-1:0];
            if (seq.done && !cpu_we)
                cpu_rdata <= cpu_hi ? cpu_word[WORD_W-1:HALF_W] : cpu_word[HALF_W-1:0];
            illegal_addr <= (ctl_act && !ctl_ok) || (seq.done && !cpu_ok);
        end
    end

    assign cpu_stall = seq.stall;

    assert_illegal_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl_act && !ctl_we && !ctl_ok)) |-> (ctl_rdata == '0));

    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl_en_n && cpu_en_n))
            |-> ($stable(ctl_rdata) && $stable(cpu_rdata) && !illegal_addr));
endmodule

// File: tb/mbox_ram_arb_bench.sv
module mbox_ram_arb_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_en_n = 1'b1, ctl_we = 1'b0;
    logic [5:0]  ctl_addr = '0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        cpu_en_n = 1'b1, cpu_we = 1'b0;
    logic [5:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_stall, illegal_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] mdl [64];

    mbox_ram_arb u_mbox_ram_arb (.*);

    always #10ns clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic legal(input int a);
        return (a >> 1) < 24;
    endfunction

    function automatic logic [15:0] expv(input int a);
        return legal(a) ? mdl[a] : 16'h0;
    endfunction

    task automatic ctl_write(input int a, input logic [15:0] d);
        ctl_en_n = 1'b0; ctl_we = 1'b1; ctl_addr = 6'(a); ctl_wdata = d;
        @(posedge clk); @(negedge clk);
        ctl_en_n = 1'b1; ctl_we = 1'b0;
        chk("R8 ctl write flag", 32'(illegal_addr), 32'(!legal(a)));
        if (legal(a)) mdl[a] = d;
    endtask

    task automatic ctl_read(input int a, input string tag);
        ctl_en_n = 1'b0; ctl_we = 1'b0; ctl_addr = 6'(a);
        @(posedge clk); @(negedge clk);
        ctl_en_n = 1'b1;
        chk(tag, 32'(ctl_rdata), 32'(expv(a)));
    endtask

    task automatic cpu_read(input int a);
        cpu_en_n = 1'b0; cpu_we = 1'b0; cpu_addr = 6'(a);
        #1ns chk("R4 read no stall", 32'(cpu_stall), 0);
        @(posedge clk); @(negedge clk);
        cpu_en_n = 1'b1;
        chk("R4/R2 cpu read data", 32'(cpu_rdata), 32'(expv(a)));
        chk("R8 cpu read flag", 32'(illegal_addr), 32'(!legal(a)));
    endtask

    task automatic cpu_write(input int a, input logic [15:0] d);
        cpu_en_n = 1'b0; cpu_we = 1'b1; cpu_addr = 6'(a); cpu_wdata = d;
        #1ns chk("R5 stall first cycle", 32'(cpu_stall), 1);
        @(posedge clk); @(negedge clk);
        #1ns chk("R5 no stall second cycle", 32'(cpu_stall), 0);
        @(posedge clk); @(negedge clk);
        cpu_en_n = 1'b1; cpu_we = 1'b0;
        chk("R8 cpu write flag", 32'(illegal_addr), 32'(!legal(a)));
        if (legal(a)) mdl[a] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 64; a++) mdl[a] = 16'h0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctl_rdata", 32'(ctl_rdata), 0);
        chk("R1 cpu_rdata", 32'(cpu_rdata), 0);
        chk("R1 stall", 32'(cpu_stall), 0);
        chk("R1 flag", 32'(illegal_addr), 0);
        for (int a = 0; a < 48; a++) ctl_read(a, "R1 entry cleared");

        // R3/R2/R8 controller fill and readback over all addresses
        for (int a = 0; a < 64; a++) ctl_write(a, 16'(a * 16'h0357 + 16'h1234));
        for (int a = 0; a < 64; a++) ctl_read(a, "R3/R2/R8 ctl readback");

        // R4 CPU reads over all addresses
        for (int a = 0; a < 64; a++) cpu_read(a);

        // R5/R6 CPU writes, partner half checked after each
        for (int a = 0; a < 64; a++) begin
            cpu_write(a, 16'(~(a * 16'h0357 + 16'h1234) ^ 16'h5A00));
            ctl_read(a ^ 1, "R6 partner half kept");
            ctl_read(a, "R6 written half");
        end

        // R7 simultaneous access: controller write wins, CPU read follows
        ctl_en_n = 1'b0; ctl_we = 1'b1; ctl_addr = 6'd6; ctl_wdata = 16'hBEEF;
        cpu_en_n = 1'b0; cpu_we = 1'b0; cpu_addr = 6'd6;
        #1ns chk("R7 stall on conflict", 32'(cpu_stall), 1);
        @(posedge clk); @(negedge clk);
        ctl_en_n = 1'b1; ctl_we = 1'b0; mdl[6] = 16'hBEEF;
        #1ns chk("R7 stall released", 32'(cpu_stall), 0);
        @(posedge clk); @(negedge clk);
        cpu_en_n = 1'b1;
        chk("R7 cpu read after ctl write", 32'(cpu_rdata), 32'h0000BEEF);

        // R7 controller hits the write-back cycle: restart keeps both halves
        cpu_en_n = 1'b0; cpu_we = 1'b1; cpu_addr = 6'd10; cpu_wdata = 16'h1111;
        @(posedge clk); @(negedge clk);
        ctl_en_n = 1'b0; ctl_we = 1'b1; ctl_addr = 6'd11; ctl_wdata = 16'h2222;
        #1ns chk("R7 stall during interference", 32'(cpu_stall), 1);
        @(posedge clk); @(negedge clk);
        ctl_en_n = 1'b1; ctl_we = 1'b0;
        #1ns chk("R7 restart read phase stalls", 32'(cpu_stall), 1);
        @(posedge clk); @(negedge clk);
        #1ns chk("R7 restart write-back", 32'(cpu_stall), 0);
        @(posedge clk); @(negedge clk);
        cpu_en_n = 1'b1; cpu_we = 1'b0;
        mdl[10] = 16'h1111; mdl[11] = 16'h2222;
        ctl_read(10, "R7 cpu half after restart");
        ctl_read(11, "R7 ctl half kept after restart");

        // R9 both enables high: nothing moves
        begin
            logic [15:0] c_hold, p_hold;
            c_hold = ctl_rdata; p_hold = cpu_rdata;
            for (int i = 0; i < 20; i++) begin
                ctl_we = 1'b1; cpu_we = 1'b1;
                ctl_addr = 6'(i * 3); cpu_addr = 6'(i * 5 + 1);
                ctl_wdata = 16'(i * 16'h1F1F); cpu_wdata = 16'(~(i * 16'h0F0F));
                @(posedge clk); @(negedge clk);
                chk("R9 ctl_rdata held", 32'(ctl_rdata), 32'(c_hold));
                chk("R9 cpu_rdata held", 32'(cpu_rdata), 32'(p_hold));
                chk("R9 flag low", 32'(illegal_addr), 0);
            end
            ctl_we = 1'b0; cpu_we = 1'b0;
        end
        for (int a = 0; a < 64; a++) ctl_read(a, "R9 contents unchanged");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule